// File: doc/BRIEF.md
# Two-Stage Lock Sequencer with Output Blanking

This block decides when two cascaded clock loops count as locked and whether the parallel data outputs they feed can be trusted. The first loop recovers the link clock. The second loop, which depends on the first, adds frequency spread. Neither loop reports lock through a phase detector. A loop counts as locked once an internal counter has run for `LOCK_CYCLES` reference clock cycles without being disturbed. The spread loop counts only while the recovery loop is locked. Losing the recovery loop therefore costs two full delays, while losing only the spread loop costs one.

The block also watches the spread setting. A move to a nonzero spread level, from either another nonzero level or from no spread, forces the data outputs low for one lock delay. A move back to no spread lets the data keep toggling, but marks it invalid for the same delay. The data-valid flag is high only when both loops are locked and no such window is running.

All inputs are synchronous to `clk`. The reset is asynchronous and active low. Its release is synchronised internally and takes two clock edges.

Top module: `dual_lock_sequencer`

## Requirements
- R1: While `rst_n` is low, and at the first two rising edges after it goes high, all four outputs are low.
- R2: `rec_locked` rises on the (`LOCK_CYCLES`+2)th rising edge after `rst_n` is released, provided `rec_lost` stays low.
- R3: The spread count runs only while `rec_locked` is high. `spr_locked` rises `LOCK_CYCLES` edges after `rec_locked` rises, and `spr_locked` never stands high while `rec_locked` is low.
- R4: An edge that samples `rec_lost` high clears both lock outputs and both counts. `rec_locked` returns `LOCK_CYCLES` edges after the first edge that samples `rec_lost` low, and `spr_locked` returns `LOCK_CYCLES` edges after that.
- R5: An edge that samples `spr_lost` high, with `rec_lost` low, clears only `spr_locked` and the spread count. `rec_locked` stays high, and `spr_locked` returns `LOCK_CYCLES` edges after the first edge that samples `spr_lost` low.
- R6: `spread_sel` is decoded as follows: 2'b00 is no spread, 2'b01 is the narrow spread, and 2'b10 and 2'b11 are both the wide spread. A move between 2'b10 and 2'b11 is not a change and has no effect on any output.
- R7: At the edge that samples a change of decoded level to narrow or wide, `out_force_low` rises. It stays high for `LOCK_CYCLES` edges, and `data_valid` is low for that time.
- R8: At the edge that samples a change of decoded level to no spread, `data_valid` falls for `LOCK_CYCLES` edges while `out_force_low` stays low.
- R9: `data_valid` is high exactly when both loops are locked and no spread-change window is running. It is never high together with `out_force_low`.
- R10: A spread change during a running window restarts the window at full length, and the most recent change decides between forcing low and invalid-only.
- R11: The first level sampled after reset is taken as the starting level and does not open a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_lost | input | 1 | Recovery loop lost lock |
| spr_lost | input | 1 | Spread loop lost lock |
| spread_sel | input | 2 | Spread level select (see R6) |
| rec_locked | output | 1 | Recovery loop lock status |
| spr_locked | output | 1 | Spread loop lock status |
| out_force_low | output | 1 | Hold the data outputs low |
| data_valid | output | 1 | Data outputs can be trusted |

## Verification
The bench attacks the following corners.

- Exact lock edges. An off-by-one counter would move a lock edge by one cycle, and the bench checks that edge.
- Recovery loss versus spread loss. A design that relocked the spread loop together with the recovery loop, or that dropped the recovery lock on a spread loss, would show the wrong lock edge.
- Direction of a spread change. Mixing up the two directions would drive `out_force_low` high on a move to no spread.
- Changes inside a running window. A design that did not restart the window, or kept the first change's mode, would end the window early or with the wrong blanking.
- Aliased wide codes. A design that compared raw codes would blank on a move between 2'b10 and 2'b11.
- The level sampled first after reset. A design that treated it as a change would start a window at power-up.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

  typedef enum logic [1:0] {
    SPR_OFF    = 2'd0,
    SPR_NARROW = 2'd1,
    SPR_WIDE   = 2'd2
  } spread_lvl_e;

  // Both upper codes select the wide spread.
  function automatic spread_lvl_e spread_level(input logic [1:0] code);
    case (code)
      2'b00:   return SPR_OFF;
      2'b01:   return SPR_NARROW;
      default: return SPR_WIDE;
    endcase
  endfunction

endpackage

// File: rtl/lockseq_rst_sync.sv
module lockseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/lockseq_timer.sv
// Lock-by-timeout counter: done rises after LOCK_CYCLES undisturbed cycles.
module lockseq_timer #(
  parameter int unsigned LOCK_CYCLES = 32800
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  output logic done
);

  localparam int unsigned CW = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | ~done_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (clr) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      done_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/lockseq_spread_watch.sv
// Tracks the decoded spread level and runs the post-change window.
module lockseq_spread_watch
  import lockseq_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 32800
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic [1:0] sel,
  output logic       window,
  output logic       hold_low
);

  localparam int unsigned CW = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  spread_lvl_e   lvl, prev_q;
  logic          seen_q;
  logic          change;
  logic          win_q, win_d;
  logic          low_q, low_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          win_en;

  always_comb begin
    lvl    = spread_level(sel);
    change = seen_q && (lvl != prev_q);
    win_en = change | win_q;
    win_d  = win_q;
    low_d  = low_q;
    cnt_d  = cnt_q;
    if (change) begin
      win_d = 1'b1;
      cnt_d = '0;
      low_d = (lvl != SPR_OFF);
    end else if (cnt_q == LAST) begin
      win_d = 1'b0;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      seen_q <= 1'b0;
      prev_q <= SPR_OFF;
    end else begin
      seen_q <= 1'b1;
      prev_q <= lvl;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      win_q <= 1'b0;
      low_q <= 1'b0;
      cnt_q <= '0;
    end else if (win_en) begin
      win_q <= win_d;
      low_q <= low_d;
      cnt_q <= cnt_d;
    end
  end

  assign window   = win_q;
  assign hold_low = win_q & low_q;

endmodule

// File: rtl/dual_lock_sequencer.sv
module dual_lock_sequencer #(
  parameter int unsigned LOCK_CYCLES = 32800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rec_lost,
  input  logic       spr_lost,
  input  logic [1:0] spread_sel,
  output logic       rec_locked,
  output logic       spr_locked,
  output logic       out_force_low,
  output logic       data_valid
);

  localparam int unsigned N_LOOPS = 2;

  logic               arst_n;
  logic [N_LOOPS-1:0] loop_clr;
  logic [N_LOOPS-1:0] loop_done;
  logic               window;
  logic               hold_low;

  lockseq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (arst_n)
  );

  // Loop 0 recovers the clock; loop 1 spreads it and waits on loop 0.
  assign loop_clr[0] = rec_lost;
  assign loop_clr[1] = rec_lost | spr_lost | ~loop_done[0];

  for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
    lockseq_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
      .clk    (clk),
      .arst_n (arst_n),
      .clr    (loop_clr[g]),
      .done   (loop_done[g])
    );
  end

  lockseq_spread_watch #(.LOCK_CYCLES(LOCK_CYCLES)) u_watch (
    .clk      (clk),
    .arst_n   (arst_n),
    .sel      (spread_sel),
    .window   (window),
    .hold_low (hold_low)
  );

  assign rec_locked    = loop_done[0];
  assign spr_locked    = loop_done[1];
  assign out_force_low = hold_low;
  assign data_valid    = loop_done[0] & loop_done[1] & ~window;

endmodule

// File: rtl/dual_lock_sequencer_chk.sv
module dual_lock_sequencer_chk
  import lockseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rec_lost,
  input logic       spr_lost,
  input logic [1:0] spread_sel,
  input logic       rec_locked,
  input logic       spr_locked,
  input logic       out_force_low,
  input logic       data_valid
);

  // R3
  spr_needs_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spr_locked |-> rec_locked);

  // R2
  rec_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_locked) |-> !spr_locked);

  // R4
  rec_loss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_lost |=> (!rec_locked && !spr_locked));

  // R5
  spr_loss_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_lost && !rec_lost && rec_locked) |=> (rec_locked && !spr_locked));

  // R9
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (rec_locked && spr_locked && !out_force_low));

  // R7
  spread_up_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && spread_level(spread_sel) != SPR_OFF &&
     spread_level(spread_sel) != spread_level($past(spread_sel))) |=> out_force_low);

  // R8
  spread_off_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spread_level(spread_sel) == SPR_OFF &&
     spread_level($past(spread_sel)) != SPR_OFF) |=> (!out_force_low && !data_valid));

endmodule

bind dual_lock_sequencer dual_lock_sequencer_chk u_chk (.*);

// File: tb/sim_dual_lock_sequencer.sv
`timescale 1ns/1ps
module sim_dual_lock_sequencer;

  localparam int unsigned N = 20;

  logic       clk;
  logic       rst_n;
  logic       rec_lost;
  logic       spr_lost;
  logic [1:0] spread_sel;
  logic       rec_locked, spr_locked, out_force_low, data_valid;

  int checks;
  int failures;

  dual_lock_sequencer #(.LOCK_CYCLES(N)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .rec_lost      (rec_lost),
    .spr_lost      (spr_lost),
    .spread_sel    (spread_sel),
    .rec_locked    (rec_locked),
    .spr_locked    (spr_locked),
    .out_force_low (out_force_low),
    .data_valid    (data_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected behaviour built from the requirements.
  function automatic int lvl_of(input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b01) return 1;
    return 2;
  endfunction

  bit m_s0, m_s1, m_rl, m_sl, m_seen, m_blank, m_low;
  int m_rc, m_sc, m_bc, m_prev;

  always @(posedge clk) begin
    bit run, old_rl;
    int lv;
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_rl = 0; m_sl = 0; m_seen = 0; m_blank = 0; m_low = 0;
      m_rc = 0; m_sc = 0; m_bc = 0; m_prev = 0;
    end else begin
      run  = m_s1;
      m_s1 = m_s0;
      m_s0 = 1;
      if (run) begin
        old_rl = m_rl;
        if (rec_lost) begin
          m_rc = 0; m_rl = 0;
        end else if (!m_rl) begin
          if (m_rc == N - 1) begin m_rc = 0; m_rl = 1; end
          else m_rc++;
        end
        if (rec_lost || spr_lost || !old_rl) begin
          m_sc = 0; m_sl = 0;
        end else if (!m_sl) begin
          if (m_sc == N - 1) begin m_sc = 0; m_sl = 1; end
          else m_sc++;
        end
        lv = lvl_of(spread_sel);
        if (m_seen && lv != m_prev) begin
          m_blank = 1; m_bc = 0; m_low = (lv != 0);
        end else if (m_blank) begin
          if (m_bc == N - 1) begin m_blank = 0; m_bc = 0; end
          else m_bc++;
        end
        m_seen = 1;
        m_prev = lv;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_compare();
    bit e_fl, e_dv;
    e_fl = m_blank & m_low;
    e_dv = m_rl & m_sl & ~m_blank;
    check(rec_locked == m_rl, "R2 R4 rec_locked", int'(rec_locked), int'(m_rl));
    check(spr_locked == m_sl, "R3 R5 spr_locked", int'(spr_locked), int'(m_sl));
    check(out_force_low == e_fl, "R7 R10 out_force_low", int'(out_force_low), int'(e_fl));
    check(data_valid == e_dv, "R8 R9 data_valid", int'(data_valid), int'(e_dv));
  endtask

  task automatic tick();
    @(negedge clk);
    model_compare();
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r;
    checks = 0;
    failures = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; rec_lost = 1'b0; spr_lost = 1'b0; spread_sel = 2'b10;
    repeat (4) tick();
    check({rec_locked, spr_locked, out_force_low, data_valid} == 4'b0, "R1 in reset",
          int'({rec_locked, spr_locked, out_force_low, data_valid}), 0);
    rst_n = 1'b1;

    // Power-up lock order, starting level is no change.
    for (int j = 1; j <= 2 * N + 2; j++) begin
      tick();
      if (j == 2)
        check({rec_locked, spr_locked, out_force_low, data_valid} == 4'b0, "R1 after release",
              int'({rec_locked, spr_locked, out_force_low, data_valid}), 0);
      if (j == N + 1) check(!rec_locked, "R2 early", int'(rec_locked), 0);
      if (j == N + 2) check(rec_locked, "R2 lock edge", int'(rec_locked), 1);
      if (j == 2 * N + 1) check(!spr_locked, "R3 early", int'(spr_locked), 0);
      if (j == 2 * N + 2) begin
        check(spr_locked, "R3 lock edge", int'(spr_locked), 1);
        check(data_valid && !out_force_low, "R11 R9 no startup window",
              int'({out_force_low, data_valid}), 1);
      end
    end

    // Wide alias codes.
    spread_sel = 2'b11;
    for (int j = 1; j <= 3; j++) begin
      tick();
      check(data_valid && !out_force_low, "R6 alias no change",
            int'({out_force_low, data_valid}), 1);
    end

    // To narrow, then to off inside the window.
    spread_sel = 2'b01;
    for (int j = 1; j <= 4; j++) begin
      tick();
      if (j == 1) check(out_force_low && !data_valid, "R7 force low",
                        int'({out_force_low, data_valid}), 2);
    end
    spread_sel = 2'b00;
    for (int j = 1; j <= N + 1; j++) begin
      tick();
      if (j == 1) check(!out_force_low && !data_valid, "R10 mode switch",
                        int'({out_force_low, data_valid}), 0);
      if (j == N) check(!data_valid, "R8 R10 window restarted", int'(data_valid), 0);
      if (j == N + 1) check(data_valid, "R8 window end", int'(data_valid), 1);
    end

    // Recovery loss: two delays.
    rec_lost = 1'b1;
    for (int j = 1; j <= 2 * N + 1; j++) begin
      tick();
      if (j == 1) begin
        rec_lost = 1'b0;
        check(!rec_locked && !spr_locked, "R4 drop",
              int'({rec_locked, spr_locked}), 0);
      end
      if (j == N) check(!rec_locked, "R4 early", int'(rec_locked), 0);
      if (j == N + 1) check(rec_locked && !spr_locked, "R4 relock",
                            int'({rec_locked, spr_locked}), 2);
      if (j == 2 * N) check(!spr_locked, "R3 spread early", int'(spr_locked), 0);
      if (j == 2 * N + 1) check(spr_locked, "R3 spread relock", int'(spr_locked), 1);
    end

    // Spread-only loss: one delay.
    spr_lost = 1'b1;
    for (int j = 1; j <= N + 1; j++) begin
      tick();
      if (j == 1) begin
        spr_lost = 1'b0;
        check(rec_locked && !spr_locked, "R5 drop",
              int'({rec_locked, spr_locked}), 2);
      end
      if (j == N) check(!spr_locked, "R5 early", int'(spr_locked), 0);
      if (j == N + 1) check(spr_locked, "R5 relock", int'(spr_locked), 1);
    end

    // Constrained random phase checked every cycle against the model.
    for (int i = 0; i < 8000; i++) begin
      tick();
      if (i == 4000) rst_n = 1'b0;
      if (i == 4003) rst_n = 1'b1;
      r = int'($urandom % 1000);
      rec_lost = (r < 4);
      spr_lost = (r >= 4 && r < 11);
      if ($urandom % 90 == 0) spread_sel = 2'($urandom % 4);
    end
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule